// File: doc/BRIEF.md
# General-Purpose Pin Unit with Per-Pin Interrupt Detection

This block drives and samples 32 bidirectional pins and drives 18 further output-only pins. Software reaches it through a 16-bit register bus. Every 32-bit setting is split across two consecutive word addresses. Each bidirectional pin can be switched between input and output. When it is an input, it can raise an interrupt.

Every bidirectional pin has its own detection settings:
- Level or edge detection.
- Polarity: active-high or active-low for level detection, rising or falling for edge detection.
- A latched status that software clears by writing a one, or a transparent status that tracks the detected condition.

The raw status vector goes to an upstream interrupt controller. So does a single interrupt line, which is the OR of every status bit that is also enabled.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all zero), every interrupt enable is zero, `irq_vec` is zero and `irq` is low.
- R2: A write with `bus_sel` and `bus_wr` high updates one 16-bit half of a 32-bit setting and leaves the other half unchanged. The even word address holds bits 15:0 and the odd word address holds bits 31:16. Reads return the same halves combinationally. The word map is:
  - 0/1: direction
  - 2/3: pin data
  - 4/5: upper output data
  - 6/7: status
  - 8/9: enable
  - 10/11: type
  - 12/13: polarity
  - 14/15: hold
- R3: A direction bit of 1 makes the pin an output: `pin_oe` is 1 and `pin_out` carries the written data bit. When the pin data words are read, an output pin returns its driven value and an input pin returns its synchronized input value.
- R4: Upper output pin 32+n is driven by bit n of the upper output data words 4/5. Word-5 bits above bit 1 are not stored and read as 0. These pins have no status bits.
- R5: With type bit 0 (level), the condition is the synchronized pin being high when the polarity bit is 1, or low when it is 0.
- R6: With type bit 1 (edge), a 0-to-1 transition of the synchronized pin is detected when the polarity bit is 1, and a 1-to-0 transition when it is 0. A transition in the other direction sets nothing.
- R7: With hold bit 1, a detected condition sets the status bit and the bit stays set until a 1 is written to it. Writing 0 leaves it unchanged. A new detection in the same cycle as the clear wins.
- R8: With hold bit 0, the status bit is the registered condition. A detected edge gives a one-cycle status pulse, and status writes have no effect.
- R9: `irq_vec` is the raw status vector. `irq` is high exactly when some status bit and its enable bit are both 1.
- R10: A pin whose direction bit is 1 never sets its status bit.
- R11: A change on `pin_in` shows up in `irq_vec` after the third rising clock edge: two synchronizer stages, then the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| pin_in | input | 32 | Asynchronous pin inputs 0..31 |
| pin_out | output | 32 | Driven values for pins 0..31 |
| pin_oe | output | 32 | Output enables for pins 0..31 |
| hi_out | output | 18 | Output-only pins 32..49 |
| irq | output | 1 | OR of enabled status bits |
| irq_vec | output | 32 | Raw status vector |

## Verification
The bench aims at the following corner cases:
- Exact latency. A design with one synchronizer stage too few or too many would raise the status a cycle early or late.
- Edge direction. A design with inverted polarity for edge detection would latch on the wrong edge.
- The one-cycle width of a transparent edge pulse. A design that held it would leave the status high.
- Status writes. A design that cleared on a written 0, or honoured the clear on transparent pins, would lose or drop status.

Further directed cases cover:
- Masking.
- Output pins that see an active level but must stay silent.
- Half-word writes that must not disturb the other half.
- The unused upper bits of the output-only word.

A long random run compares every register and output against a cycle model built from the requirements.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int WORD_W = 16;
  localparam int FULL_W = 2 * WORD_W;

  typedef enum logic [2:0] {
    RS_DIR   = 3'd0,
    RS_DATA  = 3'd1,
    RS_HIOUT = 3'd2,
    RS_STAT  = 3'd3,
    RS_EN    = 3'd4,
    RS_TYPE  = 3'd5,
    RS_POL   = 3'd6,
    RS_HOLD  = 3'd7
  } reg_sel_e;

  // Condition seen by one pin given its mode, polarity and two samples
  function automatic logic detect_hit(logic is_edge, logic act_hi,
                                      logic cur, logic prev);
    if (is_edge)
      return act_hi ? (cur & ~prev) : (~cur & prev);
    return act_hi ? cur : ~cur;
  endfunction

  // Next status bit: latched or transparent
  function automatic logic status_next(logic hold, logic stat,
                                       logic clr, logic hit);
    return hold ? ((stat & ~clr) | hit) : hit;
  endfunction

  // Replace one 16-bit half of a 32-bit word
  function automatic logic [FULL_W-1:0] put_half(logic [FULL_W-1:0] old,
                                                 logic upper,
                                                 logic [WORD_W-1:0] wd);
    logic [FULL_W-1:0] r;
    r = old;
    if (upper) r[FULL_W-1:WORD_W] = wd;
    else       r[WORD_W-1:0]      = wd;
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] get_half(logic [FULL_W-1:0] v,
                                                 logic upper);
    return upper ? v[FULL_W-1:WORD_W] : v[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/gpio_sync_bank.sv
module gpio_sync_bank #(
  parameter int N_PIN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PIN-1:0] pin_in,
  output logic [N_PIN-1:0] cur,
  output logic [N_PIN-1:0] prev
);
  logic [N_PIN-1:0] meta_q;
  logic [N_PIN-1:0] cur_q;
  logic [N_PIN-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur  = cur_q;
  assign prev = prev_q;

  // R11
  sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> (prev_q == $past(cur_q)));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int N_PIN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PIN-1:0] cur,
  input  logic [N_PIN-1:0] prev,
  input  logic [N_PIN-1:0] dir,
  input  logic [N_PIN-1:0] is_edge,
  input  logic [N_PIN-1:0] act_hi,
  input  logic [N_PIN-1:0] hold,
  input  logic [N_PIN-1:0] clr,
  output logic [N_PIN-1:0] stat,
  output logic [N_PIN-1:0] hit
);
  logic [N_PIN-1:0] stat_q;

  for (genvar i = 0; i < N_PIN; i++) begin : g_pin
    assign hit[i] = ~dir[i] & detect_hit(is_edge[i], act_hi[i], cur[i], prev[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[i] <= 1'b0;
      else        stat_q[i] <= status_next(hold[i], stat_q[i], clr[i], hit[i]);
    end
  end

  assign stat = stat_q;

  // R1
  stat_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (stat_q == '0));

  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> ((stat_q & $past(stat_q & hold & ~clr)) == $past(stat_q & hold & ~clr)));

  // R8
  through_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> ((stat_q & $past(~hold & ~hit)) == '0));

  // R10
  out_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> ((stat_q & ~$past(stat_q) & $past(dir)) == '0));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_irq_pkg::*;
#(
  parameter int N_PIN  = 32,
  parameter int N_HI   = 18,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [N_PIN-1:0]  cur,
  input  logic [N_PIN-1:0]  stat,
  output logic [N_PIN-1:0]  dir,
  output logic [N_PIN-1:0]  dout,
  output logic [N_HI-1:0]   hi,
  output logic [N_PIN-1:0]  en,
  output logic [N_PIN-1:0]  is_edge,
  output logic [N_PIN-1:0]  act_hi,
  output logic [N_PIN-1:0]  hold,
  output logic [N_PIN-1:0]  clr
);
  localparam int SEL_W = ADDR_W - 1;

  logic [N_PIN-1:0] dir_q, dout_q, en_q, typ_q, pol_q, hold_q;
  logic [N_HI-1:0]  hi_q;
  reg_sel_e         sel;
  logic             upper;
  logic             wr_go;
  logic [N_PIN-1:0] rd_pins;
  logic [FULL_W-1:0] rd_full;

  assign sel   = reg_sel_e'(bus_addr[SEL_W:1]);
  assign upper = bus_addr[0];
  assign wr_go = bus_sel & bus_wr;

  function automatic logic [N_PIN-1:0] upd_pin(logic [N_PIN-1:0] old, logic up,
                                               logic [WORD_W-1:0] wd);
    return N_PIN'(put_half(FULL_W'(old), up, wd));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
      hi_q   <= '0;
      en_q   <= '0;
      typ_q  <= '0;
      pol_q  <= '0;
      hold_q <= '0;
    end else if (wr_go) begin
      case (sel)
        RS_DIR:   dir_q  <= upd_pin(dir_q, upper, bus_wdata);
        RS_DATA:  dout_q <= upd_pin(dout_q, upper, bus_wdata);
        RS_HIOUT: hi_q   <= N_HI'(put_half(FULL_W'(hi_q), upper, bus_wdata));
        RS_EN:    en_q   <= upd_pin(en_q, upper, bus_wdata);
        RS_TYPE:  typ_q  <= upd_pin(typ_q, upper, bus_wdata);
        RS_POL:   pol_q  <= upd_pin(pol_q, upper, bus_wdata);
        RS_HOLD:  hold_q <= upd_pin(hold_q, upper, bus_wdata);
        default:  ;
      endcase
    end
  end

  // Write-one-to-clear mask for the status words
  assign clr = (wr_go && sel == RS_STAT) ? upd_pin('0, upper, bus_wdata) : '0;

  assign rd_pins = (dir_q & dout_q) | (~dir_q & cur);

  always_comb begin
    case (sel)
      RS_DIR:   rd_full = FULL_W'(dir_q);
      RS_DATA:  rd_full = FULL_W'(rd_pins);
      RS_HIOUT: rd_full = FULL_W'(hi_q);
      RS_STAT:  rd_full = FULL_W'(stat);
      RS_EN:    rd_full = FULL_W'(en_q);
      RS_TYPE:  rd_full = FULL_W'(typ_q);
      RS_POL:   rd_full = FULL_W'(pol_q);
      default:  rd_full = FULL_W'(hold_q);
    endcase
  end

  assign bus_rdata = get_half(rd_full, upper);

  assign dir     = dir_q;
  assign dout    = dout_q;
  assign hi      = hi_q;
  assign en      = en_q;
  assign is_edge = typ_q;
  assign act_hi  = pol_q;
  assign hold    = hold_q;

  // R2
  half_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && sel == RS_DIR && upper) |=> (dir_q[WORD_W-1:0] == $past(dir_q[WORD_W-1:0])));

  // R4
  hi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_go && sel == RS_HIOUT) |=> $stable(hi_q));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int N_PIN  = 32,
  parameter int N_HI   = 18,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic [N_PIN-1:0]  pin_in,
  output logic [N_PIN-1:0]  pin_out,
  output logic [N_PIN-1:0]  pin_oe,
  output logic [N_HI-1:0]   hi_out,
  output logic              irq,
  output logic [N_PIN-1:0]  irq_vec
);
  logic [N_PIN-1:0] cur, prev, stat, hit;
  logic [N_PIN-1:0] dir, dout, en, is_edge, act_hi, hold, clr;
  logic [N_HI-1:0]  hi;

  gpio_sync_bank #(.N_PIN(N_PIN)) sync_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cur(cur), .prev(prev));

  gpio_irq_detect #(.N_PIN(N_PIN)) det_i (
    .clk(clk), .rst_n(rst_n), .cur(cur), .prev(prev), .dir(dir),
    .is_edge(is_edge), .act_hi(act_hi), .hold(hold), .clr(clr),
    .stat(stat), .hit(hit));

  gpio_regfile #(.N_PIN(N_PIN), .N_HI(N_HI), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cur(cur), .stat(stat), .dir(dir), .dout(dout), .hi(hi), .en(en),
    .is_edge(is_edge), .act_hi(act_hi), .hold(hold), .clr(clr));

  assign pin_out = dout;
  assign pin_oe  = dir;
  assign hi_out  = hi;
  assign irq_vec = stat;
  assign irq     = |(stat & en);

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_vec != '0));

  // R1
  oe_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0));
endmodule

// File: tb/gpio_irq_unit_tb.sv
`timescale 1ns/1ps
module gpio_irq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [31:0] pin_in, pin_out, pin_oe, irq_vec;
  logic [17:0] hi_out;
  logic        irq;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .hi_out(hi_out),
    .irq(irq), .irq_vec(irq_vec));

  // Cycle model built from the requirements
  logic [31:0] m_dir, m_dout, m_en, m_typ, m_pol, m_hold, m_stat;
  logic [31:0] m_s1, m_s2, m_s3;
  logic [17:0] m_hi;

  function automatic logic [31:0] merge(logic [31:0] old, logic up, logic [15:0] wd);
    return up ? {wd, old[15:0]} : {old[31:16], wd};
  endfunction

  function automatic logic pin_cond(logic e, logic p, logic c, logic q);
    if (e) return p ? (c && !q) : (!c && q);
    return p ? c : !c;
  endfunction

  always @(posedge clk) begin : model
    logic [31:0] hitv, clrv, hiw;
    if (!rst_n) begin
      m_dir = 0; m_dout = 0; m_en = 0; m_typ = 0; m_pol = 0; m_hold = 0;
      m_stat = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_hi = 0;
    end else begin
      for (int i = 0; i < 32; i++)
        hitv[i] = !m_dir[i] && pin_cond(m_typ[i], m_pol[i], m_s2[i], m_s3[i]);
      clrv = 0;
      if (bus_sel && bus_wr && bus_addr[3:1] == 3'd3)
        clrv = merge(32'h0, bus_addr[0], bus_wdata);
      m_stat = (m_hold & ((m_stat & ~clrv) | hitv)) | (~m_hold & hitv);
      if (bus_sel && bus_wr) begin
        case (bus_addr[3:1])
          3'd0: m_dir  = merge(m_dir, bus_addr[0], bus_wdata);
          3'd1: m_dout = merge(m_dout, bus_addr[0], bus_wdata);
          3'd2: begin
            hiw  = merge({14'h0, m_hi}, bus_addr[0], bus_wdata);
            m_hi = hiw[17:0];
          end
          3'd4: m_en   = merge(m_en, bus_addr[0], bus_wdata);
          3'd5: m_typ  = merge(m_typ, bus_addr[0], bus_wdata);
          3'd6: m_pol  = merge(m_pol, bus_addr[0], bus_wdata);
          3'd7: m_hold = merge(m_hold, bus_addr[0], bus_wdata);
          default: ;
        endcase
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  function automatic logic [15:0] model_read(logic [3:0] a);
    logic [31:0] v;
    case (a[3:1])
      3'd0: v = m_dir;
      3'd1: v = (m_dir & m_dout) | (~m_dir & m_s2);
      3'd2: v = {14'h0, m_hi};
      3'd3: v = m_stat;
      3'd4: v = m_en;
      3'd5: v = m_typ;
      3'd6: v = m_pol;
      default: v = m_hold;
    endcase
    return a[0] ? v[31:16] : v[15:0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge
  task automatic wr(logic [3:0] a, logic [15:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_chk(logic [3:0] a, string req);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1;
    chk(req, {16'h0, bus_rdata}, {16'h0, model_read(a)});
    bus_sel = 0;
    @(negedge clk);
  endtask

  task automatic outs_chk(string req);
    #1;
    chk(req, irq_vec, m_stat);
    chk(req, {31'h0, irq}, {31'h0, |(m_stat & m_en)});
    chk(req, pin_out, m_dout);
    chk(req, pin_oe, m_dir);
    chk(req, {14'h0, hi_out}, {14'h0, m_hi});
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    pin_in = 32'hFFFF_FFF7;
    rst_n = 0;
    wait_n(4);
    rst_n = 1;
    #1;
    // R1: reset state
    chk("R1 irq_vec", irq_vec, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);
    bus_sel = 1; bus_addr = 4'd8; #1;
    chk("R1 enable low", {16'h0, bus_rdata}, 32'h0);
    bus_addr = 4'd0; #1;
    chk("R1 direction low", {16'h0, bus_rdata}, 32'h0);
    bus_sel = 0;
    @(negedge clk);
    wait_n(5);

    // R5 level-high, latched, on pin 3
    wr(4'd12, 16'h0008);
    wr(4'd14, 16'h0008);
    wr(4'd8,  16'h0008);
    wr(4'd6,  16'hFFFF);
    wr(4'd7,  16'hFFFF);
    #1;
    chk("R5 status clear before", irq_vec & 32'h8, 32'h0);
    @(negedge clk);
    pin_in[3] = 1'b1;
    wait_n(2); #1;
    chk("R11 not yet after two edges", irq_vec & 32'h8, 32'h0);
    wait_n(1); #1;
    chk("R11 R5 set after third edge", irq_vec & 32'h8, 32'h8);
    chk("R9 irq on", {31'h0, irq}, 32'h1);
    @(negedge clk);
    pin_in[3] = 1'b0;
    wait_n(5); #1;
    chk("R7 held after level gone", irq_vec & 32'h8, 32'h8);
    @(negedge clk);
    wr(4'd6, 16'h0000); #1;
    chk("R7 zero write keeps", irq_vec & 32'h8, 32'h8);
    @(negedge clk);
    wr(4'd6, 16'h0008); #1;
    chk("R7 one write clears", irq_vec & 32'h8, 32'h0);
    chk("R9 irq off", {31'h0, irq}, 32'h0);
    @(negedge clk);
    pin_in[3] = 1'b1;
    wait_n(4);
    wr(4'd8, 16'h0000); #1;
    chk("R9 raw status kept", irq_vec & 32'h8, 32'h8);
    chk("R9 masked irq", {31'h0, irq}, 32'h0);
    @(negedge clk);
    pin_in[3] = 1'b0;
    wait_n(4);
    wr(4'd6, 16'h0008);

    // R6 falling edge, latched, pin 5
    wr(4'd10, 16'h0020);
    wr(4'd14, 16'h0028);
    pin_in[5] = 1'b0;
    wait_n(2); #1;
    chk("R11 edge not yet", irq_vec & 32'h20, 32'h0);
    wait_n(1); #1;
    chk("R6 falling edge latched", irq_vec & 32'h20, 32'h20);
    @(negedge clk);
    wr(4'd6, 16'h0020);
    wait_n(4); #1;
    chk("R6 no edge no set", irq_vec & 32'h20, 32'h0);
    @(negedge clk);
    pin_in[5] = 1'b1;
    wait_n(4); #1;
    chk("R6 rising ignored when polarity 0", irq_vec & 32'h20, 32'h0);
    @(negedge clk);

    // R8 transparent edge pulse on pin 5
    wr(4'd14, 16'h0008);
    pin_in[5] = 1'b0;
    wait_n(3); #1;
    chk("R8 pulse high", irq_vec & 32'h20, 32'h20);
    wait_n(1); #1;
    chk("R8 pulse one cycle", irq_vec & 32'h20, 32'h0);
    @(negedge clk);

    // R8 transparent level-low, pin 9, clear ignored
    pin_in[9] = 1'b0;
    wait_n(4);
    wr(4'd6, 16'h0200); #1;
    chk("R8 clear ignored", irq_vec & 32'h200, 32'h200);
    @(negedge clk);
    pin_in[9] = 1'b1;
    wait_n(4); #1;
    chk("R8 follows condition", irq_vec & 32'h200, 32'h0);
    @(negedge clk);

    // R10 / R3 output pin 7
    wr(4'd0, 16'h0080);
    wr(4'd2, 16'h0080);
    pin_in[7] = 1'b0;
    wait_n(5); #1;
    chk("R10 output pin silent", irq_vec & 32'h80, 32'h0);
    chk("R3 pin_out", pin_out & 32'h80, 32'h80);
    chk("R3 pin_oe", pin_oe, 32'h0000_0080);
    bus_sel = 1; bus_addr = 4'd2; #1;
    chk("R3 data read", {16'h0, bus_rdata}, {16'h0, (pin_in[15:0] & 16'hFF7F) | 16'h0080});
    bus_sel = 0;
    @(negedge clk);

    // R4 upper output pins
    wr(4'd4, 16'hBEEF);
    wr(4'd5, 16'hFFFF); #1;
    chk("R4 hi_out", {14'h0, hi_out}, 32'h0003_BEEF);
    bus_sel = 1; bus_addr = 4'd5; #1;
    chk("R4 unused bits read 0", {16'h0, bus_rdata}, 32'h0003);
    bus_sel = 0;
    @(negedge clk);

    // R2 half-word write
    wr(4'd1, 16'hA5C3); #1;
    chk("R2 both halves", pin_oe, 32'hA5C3_0080);
    @(negedge clk);
    wr(4'd1, 16'h0000);

    // Full register sweep against the model
    for (int a = 0; a < 16; a++) rd_chk(4'(a), "R2 R3 sweep");
    outs_chk("R9 R4 sweep");
    @(negedge clk);

    // Random phase
    void'($urandom(32'h5EED_0042));
    for (int cyc = 0; cyc < 4000; cyc++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 6) pin_in[$urandom_range(0, 31)] ^= 1'b1;
      else if (r < 8) pin_in = $urandom();
      r = int'($urandom_range(0, 99));
      if (r < 30) begin
        logic [3:0] a;
        a = 4'($urandom_range(0, 15));
        if ($urandom_range(0, 2) == 0) a = {3'd3, a[0]};
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = 16'($urandom());
        outs_chk("R5 R6 R7 R8 random");
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
      end else begin
        rd_chk(4'($urandom_range(0, 15)), "R5 R6 R7 R8 random read");
        outs_chk("R9 R10 random");
      end
    end
    finish_run();
  end
endmodule